// File: doc/BRIEF.md
# Trace Buffer Sink Write Controller

This block is the memory end of a per-core trace path. Trace bytes arrive on a valid/ready stream and are written, one byte per accepted beat, into a memory window. Software describes that window with three registers: a page-aligned base, a write pointer that only needs word alignment, and a page-aligned limit. The limit register also carries the enable bit and the mode fields. Writes go from the write pointer upward. The byte stored at the last address below the limit is a wrap: the pointer returns to base and collection stops.

The block runs only in fill mode. A wrap latches a classified status (IRQ, wrap and stop flags, the "others" event class and the "filled" buffer status code), holds the interrupt line high and back-pressures the stream until software disables the block, clears the status and re-arms it. A combinational classifier reports whether the pending interrupt is a clean wrap, spurious or fatal. When the enable bit is cleared, the one byte that may still be in flight is written out before the idle output goes high.

Top module: `trace_sink_wr`

## Requirements
- R1: After reset, every register reads zero, tr_ready and irq are low, irq_class is 0 and idle is high.
- R2: Register select 0 is base, 1 is write pointer, 2 is limit and 3 is status. A base write clears the low PAGE_BITS bits and a write-pointer write clears the low ALIGN_BITS bits. Writes to base, write pointer and status are ignored while the enable bit is set.
- R3: A limit write with bit 0 set loads all of the following at once: enable (bit 0), fill mode (bits 2:1), trigger mode (bits 4:3), no-virtual-memory flag (bit 5) and a page-aligned address from bits AW-1:PAGE_BITS. The whole write is rejected, leaving the register unchanged, unless base <= write pointer < new limit.
- R4: A limit write with bit 0 clear clears only the enable bit. The stored address and mode fields stay as they were.
- R5: tr_ready is high only when the block is enabled, the fill-mode field is 00 and the stop flag is clear. Each accepted byte appears on the memory port one cycle later, at the write pointer value from before the accept. The pointer then advances by one.
- R6: Accepting a byte at address limit-1 returns the write pointer to base. In the next cycle, status reads 0x040D (IRQ, wrap and stop set, event class 0, buffer status code 1) and tr_ready is low. No further memory writes occur.
- R7: irq follows status bit 0 and stays high until software rewrites the status while disabled.
- R8: Status layout: bit 0 IRQ, bit 1 trigger, bit 2 wrap, bit 3 stop, bits 9:4 event class, bits 15:10 buffer status code. A status write replaces all fields.
- R9: irq_class is 0 when the IRQ flag is clear. With the flag set, it is 3 (fatal) if the trigger flag is set or the event class is 0x24 or 0x25. Otherwise it is 1 (wrap) if the wrap flag is set, the event class is 0, the buffer status code is 1 and the write pointer equals base. In all remaining cases it is 2 (spurious).
- R10: idle is high only when the block is disabled and no memory write is pending. A byte accepted in the same cycle as a disabling limit write is still written in the next cycle, and idle rises one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Read data of the selected register |
| tr_valid | input | 1 | Trace byte valid |
| tr_data | input | DW | Trace byte |
| tr_ready | output | 1 | Trace byte accepted when high with tr_valid |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| irq | output | 1 | Maintenance interrupt, level |
| irq_class | output | 2 | Classification of pending interrupt |
| idle | output | 1 | Disabled and drained |

## Verification
Two functions can fall in one clock edge. The first is the acceptance of a trace byte; the second is a register write that clears the enable bit. The bench provokes this by raising tr_valid and a disabling limit write in the same cycle. It then expects the byte on the memory port in the next cycle and idle one cycle later. A second overlap sits in every fill sweep: the last byte's memory write happens in the same cycle that the wrap status is latched. The bench judges this by the exact count of writes, the addresses and data of those writes, and the status read back afterwards.

// File: rtl/trsk_pkg.sv
package trsk_pkg;
  localparam int CTLW = 6;
  localparam int STW  = 16;

  localparam logic [1:0] SEL_BASE = 2'd0;
  localparam logic [1:0] SEL_WPTR = 2'd1;
  localparam logic [1:0] SEL_LIM  = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam logic [1:0] MODE_FILL  = 2'b00;
  localparam logic [5:0] EC_OTHERS  = 6'h00;
  localparam logic [5:0] EC_STAGE1  = 6'h24;
  localparam logic [5:0] EC_STAGE2  = 6'h25;
  localparam logic [5:0] BSC_FILLED = 6'h01;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_WRAP  = 2'd1,
    CLS_SPUR  = 2'd2,
    CLS_FATAL = 2'd3
  } cls_e;

  typedef struct packed {
    logic [5:0] bsc;
    logic [5:0] ec;
    logic       stop;
    logic       wrap;
    logic       trig;
    logic       irq;
  } status_t;

  typedef struct packed {
    logic       nvm;
    logic [1:0] trig_mode;
    logic [1:0] fill_mode;
    logic       en;
  } limctl_t;
endpackage

// File: rtl/trsk_regs.sv
module trsk_regs
  import trsk_pkg::*;
#(
  parameter int AW         = 16,
  parameter int PAGE_BITS  = 6,
  parameter int ALIGN_BITS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          accept,
  input  logic          wrap_hit,
  input  logic [AW-1:0] wptr_adv,
  output logic          eng_en,
  output logic [1:0]    fill_sel,
  output logic [AW-1:0] base,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] lim_addr,
  output status_t       stat
);
  limctl_t       ctl, ctl_d;
  status_t       stat_d;
  logic [AW-1:0] base_d, wptr_d, lim_d, wptr_eng, page_cand, word_cand;
  logic          sel_base, sel_wptr, sel_lim, sel_stat;

  always_comb begin
    sel_base  = reg_wr && (reg_sel == SEL_BASE);
    sel_wptr  = reg_wr && (reg_sel == SEL_WPTR);
    sel_lim   = reg_wr && (reg_sel == SEL_LIM);
    sel_stat  = reg_wr && (reg_sel == SEL_STAT);
    page_cand = {reg_wdata[AW-1:PAGE_BITS], {PAGE_BITS{1'b0}}};
    word_cand = {reg_wdata[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    wptr_eng  = accept ? wptr_adv : wptr;

    base_d = base;
    wptr_d = wptr_eng;
    lim_d  = lim_addr;
    ctl_d  = ctl;
    stat_d = stat;

    if (sel_base && !ctl.en) base_d = page_cand;
    if (sel_wptr && !ctl.en) wptr_d = word_cand;
    if (sel_lim) begin
      if (!reg_wdata[0]) begin
        ctl_d.en = 1'b0;
      end else if ((wptr_eng >= base) && (wptr_eng < page_cand)) begin
        ctl_d = limctl_t'(reg_wdata[CTLW-1:0]);
        lim_d = page_cand;
      end
    end
    if (sel_stat && !ctl.en) stat_d = status_t'(reg_wdata[STW-1:0]);
    if (wrap_hit) begin
      stat_d.irq  = 1'b1;
      stat_d.wrap = 1'b1;
      stat_d.stop = 1'b1;
      stat_d.ec   = EC_OTHERS;
      stat_d.bsc  = BSC_FILLED;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base     <= '0;
      wptr     <= '0;
      lim_addr <= '0;
      ctl      <= '0;
      stat     <= '0;
    end else begin
      base     <= base_d;
      wptr     <= wptr_d;
      lim_addr <= lim_d;
      ctl      <= ctl_d;
      stat     <= stat_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      SEL_BASE: reg_rdata = base;
      SEL_WPTR: reg_rdata = wptr;
      SEL_LIM: begin
        reg_rdata[CTLW-1:0]        = ctl;
        reg_rdata[AW-1:PAGE_BITS]  = lim_addr[AW-1:PAGE_BITS];
      end
      default:  reg_rdata[STW-1:0] = stat;
    endcase
  end

  assign eng_en   = ctl.en;
  assign fill_sel = ctl.fill_mode;
endmodule

// File: rtl/trsk_wrpath.sv
module trsk_wrpath #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [DW-1:0] tr_data,
  input  logic [AW-1:0] wptr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] lim_addr,
  output logic [AW-1:0] wptr_adv,
  output logic          wrap_hit,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  logic [AW-1:0] wptr_inc, addr_d;
  logic [DW-1:0] data_d;

  always_comb begin
    wptr_inc = wptr + {{(AW-1){1'b0}}, 1'b1};
    wrap_hit = accept && (wptr_inc == lim_addr);
    wptr_adv = wrap_hit ? base : wptr_inc;
    addr_d   = accept ? wptr : mem_addr;
    data_d   = accept ? tr_data : mem_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we    <= accept;
      mem_addr  <= addr_d;
      mem_wdata <= data_d;
    end
  end
endmodule

// File: rtl/trsk_classify.sv
module trsk_classify
  import trsk_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          irq_f,
  input  logic          trig_f,
  input  logic          wrap_f,
  input  logic [5:0]    ec,
  input  logic [5:0]    bsc,
  input  logic [AW-1:0] wptr,
  input  logic [AW-1:0] base,
  output cls_e          cls
);
  always_comb begin
    if (!irq_f)
      cls = CLS_NONE;
    else if (trig_f || (ec == EC_STAGE1) || (ec == EC_STAGE2))
      cls = CLS_FATAL;
    else if (wrap_f && (ec == EC_OTHERS) && (bsc == BSC_FILLED) && (wptr == base))
      cls = CLS_WRAP;
    else
      cls = CLS_SPUR;
  end
endmodule

// File: rtl/trace_sink_wr.sv
module trace_sink_wr
  import trsk_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int PAGE_BITS  = 6,
  parameter int ALIGN_BITS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          tr_valid,
  input  logic [DW-1:0] tr_data,
  output logic          tr_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          irq,
  output logic [1:0]    irq_class,
  output logic          idle
);
  logic          rst_meta_n, rst_sync_n;
  logic          accept, wrap_hit, eng_en;
  logic [1:0]    fill_sel;
  logic [AW-1:0] base, wptr, lim_addr, wptr_adv;
  status_t       stat;
  cls_e          cls;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign tr_ready  = eng_en && (fill_sel == MODE_FILL) && !stat.stop;
  assign accept    = tr_valid && tr_ready;
  assign irq       = stat.irq;
  assign irq_class = cls;
  assign idle      = !eng_en && !mem_we;

  trsk_regs #(.AW(AW), .PAGE_BITS(PAGE_BITS), .ALIGN_BITS(ALIGN_BITS)) u_regs (
    .clk, .rst_n(rst_sync_n), .reg_wr, .reg_sel, .reg_wdata, .reg_rdata,
    .accept, .wrap_hit, .wptr_adv, .eng_en, .fill_sel,
    .base, .wptr, .lim_addr, .stat
  );

  trsk_wrpath #(.AW(AW), .DW(DW)) u_wrpath (
    .clk, .rst_n(rst_sync_n), .accept, .tr_data, .wptr, .base, .lim_addr,
    .wptr_adv, .wrap_hit, .mem_we, .mem_addr, .mem_wdata
  );

  trsk_classify #(.AW(AW)) u_cls (
    .irq_f(stat.irq), .trig_f(stat.trig), .wrap_f(stat.wrap),
    .ec(stat.ec), .bsc(stat.bsc), .wptr, .base, .cls
  );
endmodule

// File: rtl/trsk_chk.sv
module trsk_chk
  import trsk_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tr_valid,
  input logic          tr_ready,
  input logic [DW-1:0] tr_data,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          irq,
  input logic          idle,
  input logic          eng_en,
  input logic          wrap_hit,
  input logic [AW-1:0] wptr,
  input logic [AW-1:0] base,
  input logic [AW-1:0] lim_addr,
  input status_t       stat
);
  // R3
  ptr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_en |-> (wptr >= base) && (wptr < lim_addr));

  // R5
  mem_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && tr_ready) |=> mem_we && (mem_addr == $past(wptr)) && (mem_wdata == $past(tr_data)));

  // R6
  wrap_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_hit |=> stat.stop && irq && (wptr == $past(base)));

  // R6
  stop_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat.stop |-> !tr_ready);

  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(wrap_hit) || $past(!eng_en)));

  // R2
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_en && !(tr_valid && tr_ready)) |=> $stable(stat));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (!mem_we && !tr_ready));
endmodule

bind trace_sink_wr trsk_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tr_valid(tr_valid), .tr_ready(tr_ready),
  .tr_data(tr_data), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .irq(irq), .idle(idle), .eng_en(eng_en), .wrap_hit(wrap_hit), .wptr(wptr),
  .base(base), .lim_addr(lim_addr), .stat(stat)
);

// File: tb/trace_sink_wr_bench.sv
module trace_sink_wr_bench;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int PG = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_sel = 2'd0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic          tr_valid = 1'b0;
  logic [DW-1:0] tr_data = '0;
  logic          tr_ready, mem_we, irq, idle;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [1:0]    irq_class;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  trace_sink_wr u_trace_sink_wr (
    .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata, .reg_rdata,
    .tr_valid, .tr_data, .tr_ready, .mem_we, .mem_addr, .mem_wdata,
    .irq, .irq_class, .idle
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog act=%0d exp<=150000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [AW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    reg_sel = s;
    #1 v = 32'(reg_rdata);
  endtask

  function automatic logic [1:0] exp_cls(input logic [15:0] st, input bit at_base);
    logic [5:0] ec, bsc;
    ec  = st[9:4];
    bsc = st[15:10];
    if (!st[0]) return 2'd0;
    if (st[1] || ec == 6'h24 || ec == 6'h25) return 2'd3;
    if (st[2] && ec == 6'h00 && bsc == 6'h01 && at_base) return 2'd1;
    return 2'd2;
  endfunction

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 13 + seed) & 255);
  endfunction

  task automatic run_fill(input int b, input int off, input int pages);
    int start, lim, n, i, k;
    bit acc;
    logic [31:0] v;
    start = b + off; lim = b + pages * PG; n = lim - start; i = 0; k = 0;
    wr(2'd2, 16'h0000);
    wr(2'd3, 16'h0000);
    wr(2'd0, AW'(b));
    wr(2'd1, AW'(start));
    wr(2'd2, AW'(lim | 1));
    @(negedge clk);
    tr_valid = 1'b1; tr_data = pat(0, start);
    acc = tr_ready;
    for (int c = 0; c < n + 4; c++) begin
      @(negedge clk);
      if (mem_we) begin
        chk("R5 fill address", 32'(mem_addr), 32'(start + k));
        chk("R5 fill data", 32'(mem_wdata), 32'(pat(k, start)));
        k++;
      end
      if (acc) i++;
      tr_data = pat(i, start);
      acc = tr_ready && tr_valid;
    end
    tr_valid = 1'b0;
    chk("R6 byte count before stop", k, n);
    chk("R6 ready low after wrap", 32'(tr_ready), 0);
    chk("R7 irq held after wrap", 32'(irq), 1);
    chk("R9 class is wrap", 32'(irq_class), 1);
    rd(2'd3, v); chk("R6 status after wrap", v, 32'h040D);
    rd(2'd1, v); chk("R6 pointer back at base", v, 32'(b));
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 tr_ready", 32'(tr_ready), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 idle", 32'(idle), 1);
    chk("R1 class", 32'(irq_class), 0);
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), v); chk("R1 register zero", v, 0);
    end

    // R2 alignment and R3 field load
    wr(2'd0, 16'h1234); rd(2'd0, v); chk("R2 base page aligned", v, 32'h1200);
    wr(2'd1, 16'h1237); rd(2'd1, v); chk("R2 wptr word aligned", v, 32'h1234);
    wr(2'd2, 16'h12F9); rd(2'd2, v); chk("R3 limit fields", v, 32'h12F9);
    chk("R5 ready when enabled", 32'(tr_ready), 1);
    wr(2'd0, 16'h2000); rd(2'd0, v); chk("R2 base held while enabled", v, 32'h1200);
    wr(2'd1, 16'h1260); rd(2'd1, v); chk("R2 wptr held while enabled", v, 32'h1234);
    wr(2'd3, 16'hFFFF); rd(2'd3, v); chk("R2 status held while enabled", v, 0);
    chk("R7 irq low", 32'(irq), 0);

    // R4 disable keeps fields
    wr(2'd2, 16'h0000); rd(2'd2, v); chk("R4 disable keeps fields", v, 32'h12F8);
    chk("R4 ready low when disabled", 32'(tr_ready), 0);

    // R3 rejection when wptr beyond limit
    wr(2'd1, 16'h1300);
    wr(2'd2, 16'h12C1); rd(2'd2, v); chk("R3 bad window rejected", v, 32'h12F8);
    chk("R3 still disabled", 32'(idle), 1);

    // R5 non-fill mode blocks trace
    wr(2'd1, 16'h1234);
    wr(2'd2, 16'h12C3); rd(2'd2, v); chk("R3 mode field loaded", v, 32'h12C3);
    chk("R5 ready low outside fill", 32'(tr_ready), 0);

    // R10 accept and disable in the same cycle
    wr(2'd2, 16'h12C1);
    chk("R5 ready in fill mode", 32'(tr_ready), 1);
    chk("R10 not idle when enabled", 32'(idle), 0);
    @(negedge clk);
    tr_valid = 1'b1; tr_data = 8'hA5;
    reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 16'h0000;
    @(negedge clk);
    reg_wr = 1'b0; tr_valid = 1'b0;
    chk("R10 drained write strobe", 32'(mem_we), 1);
    chk("R10 drained write address", 32'(mem_addr), 32'h1234);
    chk("R10 drained write data", 32'(mem_wdata), 32'hA5);
    chk("R10 ready low after disable", 32'(tr_ready), 0);
    chk("R10 not idle while draining", 32'(idle), 0);
    @(negedge clk);
    chk("R10 idle after drain", 32'(idle), 1);
    chk("R10 no further write", 32'(mem_we), 0);
    rd(2'd1, v); chk("R5 pointer advanced", v, 32'h1235);

    // R8 R9 R7 classification sweep
    wr(2'd0, 16'h1200);
    for (int p = 0; p < 2; p++) begin
      wr(2'd1, p == 0 ? 16'h1200 : 16'h1240);
      for (int e = 0; e < 4; e++) begin
        for (int bs = 0; bs < 2; bs++) begin
          for (int f = 0; f < 16; f++) begin
            logic [5:0] ecv;
            logic [15:0] st;
            ecv = (e == 0) ? 6'h00 : (e == 1) ? 6'h24 : (e == 2) ? 6'h25 : 6'h13;
            st = {6'(bs), ecv, 4'(f)};
            wr(2'd3, st);
            chk("R9 irq class", 32'(irq_class), 32'(exp_cls(st, p == 0)));
            chk("R7 irq follows flag", 32'(irq), 32'(st[0]));
            if (f == 5) begin
              rd(2'd3, v); chk("R8 status readback", v, 32'(st));
            end
          end
        end
      end
    end

    // R5 R6 fill sweep
    for (int bi = 0; bi < 2; bi++) begin
      for (int pg = 1; pg <= 3; pg++) begin
        for (int off = 0; off < pg * PG; off += 20) begin
          run_fill(bi * 16'h0400, off, pg);
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule